// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block takes a small 8-bit microcontroller core into power-down and brings it back out. A one-cycle sleep strobe from the core starts power-down. At that moment the block captures the interrupt-enable state, the watchdog enable, the three wake-enable bits, the ADC-busy flag and the oscillator mode. It pulses the watchdog clear, and it gates the oscillator and timers unless a conversion is still running.

While asleep the block waits for a wake source. An external reset or a watchdog timeout gives a reset request with a cause code. A port-change, comparator-change or ADC-complete event continues the program. With interrupts enabled it branches to that source's vector. With interrupts disabled it resumes at the next instruction. Every wake first waits a settling time in clocks, chosen by the oscillator mode, and then emits a single-cycle release pulse.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: In the run state, a high `sleep_i` enters sleep. `wdt_clr_o` is high for exactly one cycle, the first cycle of sleep. `sleep_i` during sleep or settling has no effect.
- R2: `clk_gate_o` is high during sleep and settling if `adc_busy_i` was low in the strobe cycle. It stays low throughout if `adc_busy_i` was high.
- R3: During sleep, `ext_rst_i` ends in `rst_req_o` with `rst_cause_o` = 2'b01. `wdt_timeout_i` ends in `rst_req_o` with `rst_cause_o` = 2'b10, but only if `wdt_en_i` was high at entry. Otherwise the timeout is ignored.
- R4: If wake sources arrive in the same cycle, the external reset wins over the watchdog timeout, and both win over continuation events.
- R5: A continuation event (bit 0 port change, bit 1 comparator change, bit 2 ADC complete) wakes the block only if its bit in `wake_en_i` was set at sleep entry. Otherwise it is ignored.
- R6: With `gie_i` high at entry, a continuation wake gives `irq_req_o` with `irq_vec_o` = 8'h06 for port, 8'h0F for comparator and 8'h0C for ADC.
- R7: With `gie_i` low at entry, a continuation wake gives `resume_o` with no interrupt request, and `irq_vec_o` stays 0.
- R8: If `wdt_en_i` is high at entry, all continuation wake enables are forced off.
- R9: The release pulse appears N clocks after the edge that samples the wake source. N is 32 for `osc_mode_i` = 0, 64 for 1, and 128 for 2 or 3.
- R10: Among simultaneous enabled continuation events, the port change wins over the comparator, and the comparator wins over the ADC.
- R11: Each release (`rst_req_o`, `irq_req_o`, `resume_o`) is a single-cycle pulse, at most one of them at a time. The cycle after it has every output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep instruction strobe |
| gie_i | input | 1 | Global interrupt enable |
| wdt_en_i | input | 1 | Watchdog enable |
| wake_en_i | input | 3 | Wake enables: port, comparator, ADC |
| wake_evt_i | input | 3 | Wake events: port, comparator, ADC |
| wdt_timeout_i | input | 1 | Watchdog timeout |
| ext_rst_i | input | 1 | External reset request |
| adc_busy_i | input | 1 | ADC conversion in progress |
| osc_mode_i | input | 2 | Oscillator mode selecting the settle time |
| clk_gate_o | output | 1 | Stop oscillator and timers |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| rst_req_o | output | 1 | Reset request pulse |
| rst_cause_o | output | 2 | Reset cause flags: 01 external, 10 watchdog |
| irq_req_o | output | 1 | Interrupt-vector request pulse |
| irq_vec_o | output | 8 | Interrupt vector address |
| resume_o | output | 1 | In-line resume pulse |

## Verification
Some properties are checked on every cycle:
- The release pulses are one-hot, single-cycle, and followed by idle outputs.
- The reset cause is a single flag.
- The vector is one of the three legal addresses.
- The watchdog clear lasts one cycle.
- The gate in the first sleep cycle matches the ADC-busy flag seen at entry.

Some behaviours can only be shown by the bench's scenarios:
- Which source wins, and how that depends on the enable and interrupt state captured at entry.
- The exact settle count for each oscillator mode.
- That masked or disabled events are ignored.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int NSRC = 3;
  localparam int VW   = 8;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_SETTLE} swc_state_e;
  typedef enum logic [1:0] {WK_NONE, WK_RST, WK_IRQ, WK_RESUME} wake_kind_e;

  localparam logic [1:0] CAUSE_EXT = 2'b01;
  localparam logic [1:0] CAUSE_WDT = 2'b10;

  // source index: 0 port change, 1 comparator, 2 adc done
  function automatic logic [VW-1:0] src_vec(input int idx);
    case (idx)
      0:       return 8'h06;
      1:       return 8'h0F;
      default: return 8'h0C;
    endcase
  endfunction
endpackage

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
  import swc_pkg::*;
(
  input  logic            ext_i,
  input  logic            wdt_i,
  input  logic [NSRC-1:0] cont_i,
  input  logic            gie_i,
  output logic            hit_o,
  output wake_kind_e      kind_o,
  output logic [1:0]      cause_o,
  output logic [VW-1:0]   vec_o
);
  logic [VW-1:0] sel_vec;

  // lowest index wins
  always_comb begin
    sel_vec = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (cont_i[i]) sel_vec = src_vec(i);
    end
  end

  always_comb begin
    hit_o   = 1'b0;
    kind_o  = WK_NONE;
    cause_o = 2'b00;
    vec_o   = '0;
    if (ext_i) begin
      hit_o   = 1'b1;
      kind_o  = WK_RST;
      cause_o = CAUSE_EXT;
    end else if (wdt_i) begin
      hit_o   = 1'b1;
      kind_o  = WK_RST;
      cause_o = CAUSE_WDT;
    end else if (|cont_i) begin
      hit_o = 1'b1;
      if (gie_i) begin
        kind_o = WK_IRQ;
        vec_o  = sel_vec;
      end else begin
        kind_o = WK_RESUME;
      end
    end
  end
endmodule

// File: rtl/swc_settle_cnt.sv
module swc_settle_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int SETTLE_RC = 32,
  parameter int SETTLE_HS = 64,
  parameter int SETTLE_LS = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_i,
  input  logic            gie_i,
  input  logic            wdt_en_i,
  input  logic [NSRC-1:0] wake_en_i,
  input  logic [NSRC-1:0] wake_evt_i,
  input  logic            wdt_timeout_i,
  input  logic            ext_rst_i,
  input  logic            adc_busy_i,
  input  logic [1:0]      osc_mode_i,
  output logic            clk_gate_o,
  output logic            wdt_clr_o,
  output logic            rst_req_o,
  output logic [1:0]      rst_cause_o,
  output logic            irq_req_o,
  output logic [VW-1:0]   irq_vec_o,
  output logic            resume_o
);
  localparam int MAXS = (SETTLE_LS > SETTLE_HS) ?
                        ((SETTLE_LS > SETTLE_RC) ? SETTLE_LS : SETTLE_RC) :
                        ((SETTLE_HS > SETTLE_RC) ? SETTLE_HS : SETTLE_RC);
  localparam int CW = $clog2(MAXS + 1);

  swc_state_e      state_q;
  logic            gie_q, wdt_en_q, adc_q, wdt_clr_q;
  logic [NSRC-1:0] en_q;
  logic [CW-1:0]   settle_q, settle_sel;
  wake_kind_e      kind_q;
  logic [1:0]      cause_q;
  logic [VW-1:0]   vec_q;

  logic            arb_hit;
  wake_kind_e      arb_kind;
  logic [1:0]      arb_cause;
  logic [VW-1:0]   arb_vec;
  logic            cnt_load, cnt_done, release_w;
  logic            enter_w, wake_w;

  always_comb begin
    case (osc_mode_i)
      2'd0:    settle_sel = CW'(SETTLE_RC - 1);
      2'd1:    settle_sel = CW'(SETTLE_HS - 1);
      default: settle_sel = CW'(SETTLE_LS - 1);
    endcase
  end

  assign enter_w = (state_q == ST_RUN) && sleep_i;
  assign wake_w  = (state_q == ST_SLEEP) && arb_hit;

  swc_wake_arb u_arb (
    .ext_i   (ext_rst_i),
    .wdt_i   (wdt_timeout_i & wdt_en_q),
    .cont_i  (wake_evt_i & en_q),
    .gie_i   (gie_q),
    .hit_o   (arb_hit),
    .kind_o  (arb_kind),
    .cause_o (arb_cause),
    .vec_o   (arb_vec)
  );

  assign cnt_load = wake_w;

  swc_settle_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (settle_q),
    .done_o     (cnt_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      gie_q     <= 1'b0;
      wdt_en_q  <= 1'b0;
      adc_q     <= 1'b0;
      en_q      <= '0;
      settle_q  <= '0;
      wdt_clr_q <= 1'b0;
      kind_q    <= WK_NONE;
      cause_q   <= 2'b00;
      vec_q     <= '0;
    end else begin
      wdt_clr_q <= enter_w;
      case (state_q)
        ST_RUN: if (sleep_i) begin
          state_q  <= ST_SLEEP;
          gie_q    <= gie_i;
          wdt_en_q <= wdt_en_i;
          adc_q    <= adc_busy_i;
          en_q     <= wake_en_i & ~{NSRC{wdt_en_i}};
          settle_q <= settle_sel;
        end
        ST_SLEEP: if (arb_hit) begin
          state_q <= ST_SETTLE;
          kind_q  <= arb_kind;
          cause_q <= arb_cause;
          vec_q   <= arb_vec;
        end
        ST_SETTLE: if (cnt_done) state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign release_w   = (state_q == ST_SETTLE) && cnt_done;
  assign clk_gate_o  = (state_q != ST_RUN) && !adc_q;
  assign wdt_clr_o   = wdt_clr_q;
  assign rst_req_o   = release_w && (kind_q == WK_RST);
  assign rst_cause_o = rst_req_o ? cause_q : 2'b00;
  assign irq_req_o   = release_w && (kind_q == WK_IRQ);
  assign irq_vec_o   = irq_req_o ? vec_q : '0;
  assign resume_o    = release_w && (kind_q == WK_RESUME);
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       adc_busy_i,
  input logic       clk_gate_o,
  input logic       wdt_clr_o,
  input logic       rst_req_o,
  input logic [1:0] rst_cause_o,
  input logic       irq_req_o,
  input logic [7:0] irq_vec_o,
  input logic       resume_o
);
  logic rel;
  assign rel = rst_req_o | irq_req_o | resume_o;

  p_wdt_clr_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o);

  p_gate_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |-> (clk_gate_o == !$past(adc_busy_i)));

  p_cause_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $onehot(rst_cause_o));

  p_vec_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o == 8'h06 || irq_vec_o == 8'h0F || irq_vec_o == 8'h0C));

  p_no_vec_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (irq_vec_o == 8'h00));

  p_release_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_req_o, irq_req_o, resume_o}));

  p_idle_after_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel |=> (!rel && !clk_gate_o && !wdt_clr_o));
endmodule

bind sleep_wake_ctrl swc_checker i_swc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adc_busy_i  (adc_busy_i),
  .clk_gate_o  (clk_gate_o),
  .wdt_clr_o   (wdt_clr_o),
  .rst_req_o   (rst_req_o),
  .rst_cause_o (rst_cause_o),
  .irq_req_o   (irq_req_o),
  .irq_vec_o   (irq_vec_o),
  .resume_o    (resume_o)
);

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep, gie, wdt_en, wdt_to, ext_rst, adc_busy;
  logic [2:0] wake_en, wake_evt;
  logic [1:0] osc_mode;
  logic       clk_gate, wdt_clr, rst_req, irq_req, resume;
  logic [1:0] rst_cause;
  logic [7:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sleep_wake_ctrl i_sleep_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .gie_i(gie), .wdt_en_i(wdt_en),
    .wake_en_i(wake_en), .wake_evt_i(wake_evt), .wdt_timeout_i(wdt_to),
    .ext_rst_i(ext_rst), .adc_busy_i(adc_busy), .osc_mode_i(osc_mode),
    .clk_gate_o(clk_gate), .wdt_clr_o(wdt_clr), .rst_req_o(rst_req),
    .rst_cause_o(rst_cause), .irq_req_o(irq_req), .irq_vec_o(irq_vec),
    .resume_o(resume)
  );

  // kind: 0 none, 1 reset, 2 irq, 3 resume
  typedef struct packed {
    logic       gie;
    logic       wdt_en;
    logic [2:0] en;
    logic [2:0] evt;
    logic       ext;
    logic       wto;
    logic       adc;
    logic [1:0] osc;
    logic [1:0] kind;
    logic [1:0] cause;
    logic [7:0] vec;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 2'b00, 8'h06},
    '{1'b1, 1'b0, 3'b010, 3'b010, 1'b0, 1'b0, 1'b0, 2'd1, 2'd2, 2'b00, 8'h0F},
    '{1'b1, 1'b0, 3'b100, 3'b100, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 2'b00, 8'h0C},
    '{1'b0, 1'b0, 3'b001, 3'b001, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 2'b00, 8'h00},
    '{1'b0, 1'b0, 3'b010, 3'b010, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 2'b00, 8'h00},
    '{1'b0, 1'b0, 3'b100, 3'b100, 1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 2'b00, 8'h00},
    '{1'b1, 1'b0, 3'b111, 3'b111, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 2'b00, 8'h06},
    '{1'b1, 1'b0, 3'b110, 3'b110, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 2'b00, 8'h0F},
    '{1'b1, 1'b1, 3'b111, 3'b111, 1'b1, 1'b1, 1'b0, 2'd0, 2'd1, 2'b01, 8'h00},
    '{1'b1, 1'b1, 3'b111, 3'b111, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 2'b10, 8'h00},
    '{1'b1, 1'b1, 3'b111, 3'b111, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'b00, 8'h00},
    '{1'b1, 1'b0, 3'b000, 3'b111, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'b00, 8'h00},
    '{1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'b00, 8'h00},
    '{1'b0, 1'b0, 3'b011, 3'b010, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 2'b00, 8'h00}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int settle_of(input logic [1:0] m);
    return (m == 2'd0) ? 32 : (m == 2'd1) ? 64 : 128;
  endfunction

  task automatic idle_inputs();
    sleep = 0; gie = 0; wdt_en = 0; wdt_to = 0; ext_rst = 0; adc_busy = 0;
    wake_en = '0; wake_evt = '0; osc_mode = '0;
  endtask

  task automatic enter_sleep(input vec_t v);
    @(negedge clk);
    sleep = 1; gie = v.gie; wdt_en = v.wdt_en; wake_en = v.en; adc_busy = v.adc; osc_mode = v.osc;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R1", "wdt_clr on entry", int'(wdt_clr), 1);
    check("R2", "clk_gate in sleep", int'(clk_gate), int'(!v.adc));
    @(posedge clk); @(negedge clk);
    check("R1", "wdt_clr one cycle", int'(wdt_clr), 0);
  endtask

  // drives sources at a negedge, counts edges until a release pulse
  task automatic wake(input logic [2:0] evt, input logic ext, input logic wto, output int n);
    wake_evt = evt; ext_rst = ext; wdt_to = wto;
    n = 0;
    @(posedge clk); @(negedge clk);
    wake_evt = '0; ext_rst = 0; wdt_to = 0;
    n = 1;
    while (!(rst_req || irq_req || resume) && n < 300) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R11", "reset gate", int'(clk_gate), 0);
    check("R11", "reset releases", int'({rst_req, irq_req, resume, wdt_clr}), 0);
    rst_n = 1;
    @(negedge clk);

    // events while running do nothing (R5, R11)
    wake_evt = 3'b111; ext_rst = 1; wdt_to = 1;
    repeat (3) @(negedge clk);
    check("R11", "run ignores events", int'({clk_gate, rst_req, irq_req, resume}), 0);
    idle_inputs();

    foreach (TBL[i]) begin
      vec_t v = TBL[i];
      enter_sleep(v);
      if (v.kind == 2'd0) begin
        wake(v.evt, v.ext, v.wto, n);
        check("R5/R8", "ignored event gives no release", n, 300);
        check("R5/R8", "still gated", int'(clk_gate), 1);
        wake(3'b000, 1'b1, 1'b0, n);
        check("R3", "recovery reset cause", int'(rst_cause), 1);
      end else begin
        wake(v.evt, v.ext, v.wto, n);
        check("R9", "settle count", n, settle_of(v.osc));
        check("R3", "rst_req", int'(rst_req), int'(v.kind == 2'd1));
        check("R6", "irq_req", int'(irq_req), int'(v.kind == 2'd2));
        check("R7", "resume", int'(resume), int'(v.kind == 2'd3));
        check("R4", "rst_cause", int'(rst_cause), int'(v.cause));
        check("R10", "irq_vec", int'(irq_vec), int'(v.vec));
      end
      @(posedge clk); @(negedge clk);
      check("R11", "idle after release", int'({clk_gate, rst_req, irq_req, resume, wdt_clr}), 0);
    end

    // sleep strobe inside sleep has no effect (R1)
    begin
      vec_t v = '{1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 2'b00, 8'h06};
      enter_sleep(v);
      sleep = 1;
      @(posedge clk); @(negedge clk);
      sleep = 0;
      @(posedge clk); @(negedge clk);
      check("R1", "no second wdt_clr", int'(wdt_clr), 0);
      wake(3'b001, 1'b0, 1'b0, n);
      check("R9", "settle after re-strobe", n, 32);
      check("R6", "vector after re-strobe", int'(irq_vec), 8'h06);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule